// File: doc/BRIEF.md
# Quasi-Bidirectional I2C Port Expander

This block is an I2C target that owns eight port lines and an active-low interrupt. Each line has one latch bit and no direction register. A latch bit of one releases the line to a weak pull-up, so an outside circuit can drive it and the line works as an input. A latch bit of zero pulls the line low. The level seen on a line is the logical AND of the latch bit and the synchronized external level. A line therefore reads low when either side pulls it down.

A controller writes one byte per data phase to load the latch. A data phase reads back the resolved line levels, most significant line first. Every read stores the returned byte as a reference. The interrupt goes low whenever the resolved levels move away from that reference. A read releases it. After a write it is set again from a fresh comparison with the reference.

SCL and SDA are oversampled on the system clock. START and STOP conditions are recognised anywhere, and a repeated START restarts address decoding. The target answers the 7-bit address formed by the fixed prefix 4'b0100 followed by the three strap inputs. This block has no streaming interface, so all of its pins are plain level signals.

Top module: `gpx_expander`

## Requirements
- R1: After reset, irq_n is 1, line_level is 8'hFF, line_drv_low is 8'h00, sda_oe is 0, and the read reference holds 8'hFF.
- R2: The target ACKs (holds SDA low during the ninth clock) only the address {4'b0100, addr_strap}. Any other address is NACKed and changes no line or interrupt state.
- R3: A written data byte is ACKed and loads the latch. It is applied to all eight lines in one cycle. Bit k = 0 sets line_drv_low[k] to 1, and bit k = 1 releases the line.
- R4: line_level[k] equals the synchronized pin_in[k] AND latch bit k. A change on an input whose latch bit is 0 leaves line_level unchanged.
- R5: A read data byte returns line_level, most significant bit first. The target releases SDA for the controller's acknowledge bit.
- R6: Each read data byte stores the returned value as the new reference and drives irq_n to 1.
- R7: When line_level changes to a value different from the reference, irq_n goes to 0. A change that ends equal to the reference, or no change at all, leaves irq_n as it was.
- R8: After each written byte, irq_n becomes 1 if the new line_level equals the reference. Otherwise it becomes 0.
- R9: If the controller ACKs a read byte, the next byte samples line_level again and performs the same reference update and interrupt release. A NACK ends the read.
- R10: Several data bytes in one write transaction are each ACKed and applied in order, so the last byte sets the final latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock level from the bus |
| sda_i | input | 1 | I2C data level from the bus (wired-AND) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK bit or a zero data bit) |
| addr_strap | input | 3 | Low three bits of the target address |
| pin_in | input | 8 | External level on each port line (asynchronous) |
| line_level | output | 8 | Resolved level of each port line |
| line_drv_low | output | 8 | 1 where the expander pulls the line low |
| irq_n | output | 1 | Active-low change interrupt |

## Verification
If the latch is corrupted, the error shows on line_drv_low in the cycle after the faulty update, and on line_level at the same time. A wrong reference does not show at the ports until the next pin change or write. At that point irq_n takes the wrong value within a few cycles, so the bench follows every write and pin change with a check of irq_n. A fault in the FSM shows as a missing or misplaced ACK, or as shifted read bits, within the same byte. A reference model updated at each transaction is compared with all three outputs on every quiet clock.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int LINES = 8;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } tgt_state_t;
endpackage

// File: rtl/gpx_bus_sampler.sv
module gpx_bus_sampler #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;
  logic scl_s, sda_s;

  assign scl_s = scl_sh[SYNC-1];
  assign sda_s = sda_sh[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign sda_lvl   = sda_s;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/gpx_target_fsm.sv
module gpx_target_fsm
  import gpx_pkg::*;
#(
  parameter logic [3:0] ADDR_PREFIX = 4'b0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [2:0]       addr_strap,
  input  logic [LINES-1:0] tx_byte,
  output logic             sda_oe,
  output logic             wr_stb,
  output logic [LINES-1:0] wr_byte,
  output logic             rd_stb
);
  tgt_state_t       state;
  logic [3:0]       bitcnt;
  logic [LINES-1:0] shreg, txsh;
  logic             rw, more_q, match;

  assign match   = (shreg[7:1] == {ADDR_PREFIX, addr_strap});
  assign wr_byte = shreg;
  assign wr_stb  = !start_det && !stop_det && scl_fall &&
                   state == ST_WR && bitcnt == 4'd8;
  assign rd_stb  = !start_det && !stop_det && scl_fall &&
                   ((state == ST_ADDR_ACK && rw) || (state == ST_RD_ACK && more_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txsh   <= '0;
      rw     <= 1'b0;
      more_q <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_lvl};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (state == ST_WR) begin
              sda_oe <= 1'b1;
              state  <= ST_WR_ACK;
            end else if (match) begin
              sda_oe <= 1'b1;
              rw     <= shreg[0];
              state  <= ST_ADDR_ACK;
            end else begin
              state  <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK, ST_RD_ACK: begin
          if (scl_rise && state == ST_RD_ACK) begin
            more_q <= ~sda_lvl;
          end else if (scl_fall) begin
            bitcnt <= '0;
            if (rd_stb) begin
              txsh   <= tx_byte;
              sda_oe <= ~tx_byte[7];
              state  <= ST_RD;
            end else if (state == ST_ADDR_ACK) begin
              sda_oe <= 1'b0;
              state  <= ST_WR;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_IDLE;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe <= 1'b0;
              more_q <= 1'b0;
              state  <= ST_RD_ACK;
            end else begin
              txsh   <= {txsh[6:0], 1'b0};
              sda_oe <= ~txsh[6];
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  addr_ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_ACK) |-> (shreg[7:1] == {ADDR_PREFIX, addr_strap}));

  // R5
  sda_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state == ST_ADDR_ACK || state == ST_WR_ACK || state == ST_RD));

  // R9
  rd_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (state == ST_RD));
endmodule

// File: rtl/gpx_port_core.sv
module gpx_port_core
  import gpx_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_in,
  input  logic             wr_stb,
  input  logic [LINES-1:0] wr_byte,
  input  logic             rd_stb,
  output logic [LINES-1:0] line_level,
  output logic [LINES-1:0] line_drv_low,
  output logic             irq_n
);
  logic [LINES-1:0] in_sh [SYNC];
  logic [LINES-1:0] latch, prev_level, ref_q;
  logic             wr_done;

  assign line_level   = in_sh[SYNC-1] & latch;
  assign line_drv_low = ~latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) in_sh[i] <= '1;
      latch      <= '1;
      prev_level <= '1;
      ref_q      <= '1;
      wr_done    <= 1'b0;
      irq_n      <= 1'b1;
    end else begin
      in_sh[0] <= pin_in;
      for (int i = 1; i < SYNC; i++) in_sh[i] <= in_sh[i-1];
      if (wr_stb) latch <= wr_byte;
      wr_done    <= wr_stb;
      prev_level <= line_level;
      if (rd_stb) begin
        ref_q <= line_level;
        irq_n <= 1'b1;
      end else if (wr_done) begin
        irq_n <= (line_level == ref_q);
      end else if (line_level != prev_level && line_level != ref_q) begin
        irq_n <= 1'b0;
      end
    end
  end

  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> irq_n);

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(line_drv_low));

  // R8
  irq_release_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> ($past(rd_stb) || $past(wr_done)));

  // R7
  irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past(line_level) != $past(ref_q)));
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
  import gpx_pkg::*;
#(
  parameter int         SYNC        = 2,
  parameter logic [3:0] ADDR_PREFIX = 4'b0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [2:0]       addr_strap,
  input  logic [LINES-1:0] pin_in,
  output logic [LINES-1:0] line_level,
  output logic [LINES-1:0] line_drv_low,
  output logic             irq_n
);
  logic scl_rise, scl_fall, sda_lvl, start_det, stop_det;
  logic wr_stb, rd_stb;
  logic [LINES-1:0] wr_byte;

  gpx_bus_sampler #(.SYNC(SYNC)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .start_det(start_det), .stop_det(stop_det)
  );

  gpx_target_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .start_det(start_det), .stop_det(stop_det),
    .addr_strap(addr_strap), .tx_byte(line_level), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .rd_stb(rd_stb)
  );

  gpx_port_core #(.SYNC(SYNC)) u_core (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_stb(wr_stb),
    .wr_byte(wr_byte), .rd_stb(rd_stb), .line_level(line_level),
    .line_drv_low(line_drv_low), .irq_n(irq_n)
  );
endmodule

// File: tb/gpx_expander_bench.sv
module gpx_expander_bench;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_drv = 1'b1, sda_drv = 1'b1;
  logic [2:0] addr_strap = 3'b101;
  logic [7:0] pin_in = 8'hFF;
  logic       sda_oe, irq_n;
  logic [7:0] line_level, line_drv_low;
  logic       sda_line;

  int errors = 0, checks = 0, cyc = 0;
  logic cmp_en = 1'b0;
  logic [7:0] m_latch = 8'hFF, m_in = 8'hFF, m_ref = 8'hFF;
  logic       m_irqn = 1'b1;

  assign sda_line = sda_drv & ~sda_oe;

  always #5 clk = ~clk;

  gpx_expander u_gpx_expander (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_oe(sda_oe), .addr_strap(addr_strap), .pin_in(pin_in),
    .line_level(line_level), .line_drv_low(line_drv_low), .irq_n(irq_n)
  );

  function automatic logic [7:0] m_level();
    return m_in & m_latch;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Per-clock comparison against the reference model while the bus is quiet (R3, R4, R7)
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cmp_en) begin
      chk("R4 line_level", line_level, m_level());
      chk("R3 line_drv_low", line_drv_low, ~m_latch);
      chk("R7 irq_n", {7'd0, irq_n}, {7'd0, m_irqn});
    end
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; scl_drv = 1'b1; qw();
    sda_drv = 1'b0; qw();
    scl_drv = 1'b0; qw();
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; qw();
    scl_drv = 1'b1; qw();
    sda_drv = 1'b1; qw();
  endtask

  task automatic send_bit(input logic b);
    sda_drv = b; qw();
    scl_drv = 1'b1; qw(); qw();
    scl_drv = 1'b0; qw();
  endtask

  task automatic recv_bit(output logic b);
    sda_drv = 1'b1; qw();
    scl_drv = 1'b1; qw();
    b = sda_line; qw();
    scl_drv = 1'b0; qw();
  endtask

  task automatic put_byte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    acked = !a;
  endtask

  task automatic get_byte(output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
    cmp_en = 1'b1;
  endtask

  task automatic write_one(input logic [7:0] d, input string tag);
    logic ack;
    cmp_en = 1'b0;
    i2c_start();
    put_byte({4'b0100, addr_strap, 1'b0}, ack);
    chk({tag, " R2 addr ack"}, {7'd0, ack}, 8'd1);
    put_byte(d, ack);
    chk({tag, " R3 data ack"}, {7'd0, ack}, 8'd1);
    m_latch = d;
    m_irqn  = (m_level() == m_ref);
    i2c_stop();
    settle();
    chk({tag, " R8 irq after write"}, {7'd0, irq_n}, {7'd0, m_irqn});
  endtask

  task automatic read_one(input string tag);
    logic ack;
    logic [7:0] d;
    cmp_en = 1'b0;
    i2c_start();
    put_byte({4'b0100, addr_strap, 1'b1}, ack);
    chk({tag, " R2 addr ack"}, {7'd0, ack}, 8'd1);
    get_byte(d);
    chk({tag, " R5 read data"}, d, m_level());
    m_ref  = m_level();
    m_irqn = 1'b1;
    send_bit(1'b1);
    i2c_stop();
    settle();
    chk({tag, " R6 irq released"}, {7'd0, irq_n}, 8'd1);
  endtask

  task automatic set_pins(input logic [7:0] v);
    logic [7:0] old;
    cmp_en = 1'b0;
    old = m_level();
    pin_in = v;
    m_in = v;
    if (m_level() != old && m_level() != m_ref) m_irqn = 1'b0;
    settle();
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 irq_n", {7'd0, irq_n}, 8'd1);
    chk("R1 line_level", line_level, 8'hFF);
    chk("R1 line_drv_low", line_drv_low, 8'h00);
    chk("R1 sda_oe", {7'd0, sda_oe}, 8'd0);
    cmp_en = 1'b1;

    // R2 wrong address: NACK, no effect
    cmp_en = 1'b0;
    i2c_start();
    put_byte({4'b0100, 3'b010, 1'b0}, ack);
    chk("R2 mismatch nack", {7'd0, ack}, 8'd0);
    put_byte(8'h00, ack);
    chk("R2 data ignored nack", {7'd0, ack}, 8'd0);
    i2c_stop();
    settle();
    chk("R2 latch untouched", line_drv_low, 8'h00);

    write_one(8'h5A, "w1");          // R3 R4 R8: level 5A != ref FF
    chk("R8 irq asserted", {7'd0, irq_n}, 8'd0);
    read_one("r1");                   // R5 R6
    set_pins(8'hF0);                  // R7: level 50 differs from ref 5A
    chk("R7 irq on change", {7'd0, irq_n}, 8'd0);
    read_one("r2");
    set_pins(8'hF1);                  // R4: bit0 latch is 0, no level change
    chk("R4 masked input", line_level, 8'h50);
    chk("R7 no irq", {7'd0, irq_n}, 8'd1);
    write_one(8'h50, "w2");           // R8: level equals ref
    chk("R8 irq stays high", {7'd0, irq_n}, 8'd1);
    write_one(8'hFF, "w3");           // R8: level F1 != ref 50
    chk("R8 irq low", {7'd0, irq_n}, 8'd0);
    read_one("r3");
    set_pins(8'hFF);
    set_pins(8'hF1);                  // R7: back to ref, irq stays low
    chk("R7 return to ref", {7'd0, irq_n}, 8'd0);
    read_one("r4");

    // R10 multi-byte write
    cmp_en = 1'b0;
    i2c_start();
    put_byte({4'b0100, addr_strap, 1'b0}, ack);
    put_byte(8'h0F, ack);
    chk("R10 byte1 ack", {7'd0, ack}, 8'd1);
    repeat (4) @(negedge clk);
    chk("R10 byte1 applied", line_drv_low, 8'hF0);
    put_byte(8'h33, ack);
    chk("R10 byte2 ack", {7'd0, ack}, 8'd1);
    m_latch = 8'h33;
    m_irqn = (m_level() == m_ref);
    i2c_stop();
    settle();
    chk("R10 final latch", line_drv_low, 8'hCC);

    // R9 multi-byte read with a pin change between bytes
    cmp_en = 1'b0;
    i2c_start();
    put_byte({4'b0100, addr_strap, 1'b1}, ack);
    get_byte(d);
    chk("R9 byte1", d, m_level());
    m_ref = m_level();
    repeat (10) @(negedge clk);
    chk("R9 irq released byte1", {7'd0, irq_n}, 8'd1);
    pin_in = 8'h0F;
    m_in = 8'h0F;
    repeat (10) @(negedge clk);
    chk("R9 irq on mid-read change", {7'd0, irq_n}, 8'd0);
    send_bit(1'b0);
    get_byte(d);
    chk("R9 byte2 resampled", d, 8'h03);
    m_ref = 8'h03;
    m_irqn = 1'b1;
    send_bit(1'b1);
    i2c_stop();
    settle();
    chk("R9 irq released byte2", {7'd0, irq_n}, 8'd1);

    // R2 other strap value
    addr_strap = 3'b010;
    repeat (4) @(negedge clk);
    write_one(8'hFF, "w4");
    read_one("r5");

    repeat (20) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule